// File: doc/BRIEF.md
# Thermal Sensor Code to Junction Temperature Converter

This block turns the raw codes from an on-die thermal sensor ADC into a calibrated junction temperature in millidegrees Celsius. A start pulse arms a conversion. The block then collects a fixed group of sample words, which it reads through a valid/data port, and averages them. It corrects the average for sensor curvature and applies a two-point linear calibration. The calibration endpoints come from two trim words. A trim word may be unprogrammed, and in that case a built-in default endpoint is used. The result is rounded up onto a 500 m°C grid and presented with a one-cycle done pulse.

All arithmetic is integer. The three divisions share one restoring divider that produces one quotient bit per clock, so a conversion takes roughly a hundred cycles after the last sample. A busy flag is high while a conversion is in flight. Start pulses that arrive during this time are dropped. If the trim endpoints are not in increasing order, the result cannot be computed. The block then raises an error flag and outputs zero instead of dividing.

Top module: `thermo_code_conv`

## Requirements
- R1: Only bits 11:0 of each sample word form the sensor code; bits 15:12 have no effect on the result.
- R2: A conversion sums exactly 8 accepted samples and forms the average code as the sum divided by 8, truncated.
- R3: The corrected code is avg·1,000,000 / (1,000,000 + 13·avg), truncated.
- R4: A trim word counts as programmed when its bit 31 is 1, and its endpoint is then bits 11:0. When bit 31 is 0, the hot endpoint (trim_hot) defaults to 3148 and the cold endpoint (trim_cold) defaults to 503. Both trim words are captured in the start cycle, so later changes do not affect the running conversion.
- R5: The temperature before rounding is (corrected − cold) · trunc(165,000 / (hot − cold)) − 40,000 m°C. It is computed in signed 32-bit arithmetic, so results below the cold point are negative.
- R6: The output temperature is the unrounded value rounded toward plus infinity to a multiple of 500.
- R7: When hot ≤ cold, the conversion ends with err = 1 and temp_mc = 0. Otherwise err = 0 with the result.
- R8: busy is 1 from the cycle after an accepted start until the done cycle. A start while busy is ignored: it does not clear the collected samples or restart the conversion.
- R9: Samples presented while no conversion is armed are ignored. An accepted start clears the sum and the sample count.
- R10: done is a single-cycle pulse. temp_mc and err keep their values until the next done.
- R11: After reset, temp_mc = 0, err = 0, done = 0 and busy = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that arms a conversion when idle |
| smp_vld | input | 1 | Sample word valid |
| smp_data | input | 16 | Sample word; low 12 bits are the code |
| trim_hot | input | 32 | Hot-endpoint trim word (bit 31 programmed, bits 11:0 value) |
| trim_cold | input | 32 | Cold-endpoint trim word (bit 31 programmed, bits 11:0 value) |
| temp_mc | output | 32 | Signed temperature in m°C |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Calibration endpoints invalid for the last result |
| busy | output | 1 | Conversion in flight |

## Verification
The hardest situation to produce is a start pulse that arrives in the middle of sample collection. If that pulse is not ignored, it silently restarts the sum. The bench sends four samples, pulses start, and then sends four more. The result must match the average of all eight. It also changes the trim words partway through a conversion, including to an invalid pair, and expects the values captured at start. Negative results and exact rounding behaviour are reached by choosing average codes below the cold endpoint.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    localparam int unsigned CORR_SCALE = 1000000;
    localparam int unsigned CURV_K     = 13;
    localparam int unsigned SPAN_MC    = 165000;
    localparam int unsigned OFFSET_MC  = 40000;
    localparam int unsigned GRAN_MC    = 500;
    localparam int unsigned HOT_DEF    = 3148;
    localparam int unsigned COLD_DEF   = 503;

    typedef enum logic [3:0] {
        S_IDLE, S_ACC, S_CORR_GO, S_CORR_WT, S_SCL_GO,
        S_SCL_WT, S_MUL, S_QNT_GO, S_QNT_WT
    } conv_st_t;
endpackage

// File: rtl/thermo_trim.sv
module thermo_trim #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned VAL_W   = 12,
    parameter int unsigned DEFAULT = 0
) (
    input  logic [WORD_W-1:0] word,
    output logic [VAL_W-1:0]  val
);
    localparam int unsigned FLAG_BIT = WORD_W - 1;

    logic unused_mid;
    assign unused_mid = ^word[FLAG_BIT-1:VAL_W];

    always_comb begin
        val = word[FLAG_BIT] ? word[VAL_W-1:0] : VAL_W'(DEFAULT);
    end
endmodule

// File: rtl/thermo_div.sv
module thermo_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         vld
);
    localparam int unsigned CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          vld;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } dv_t;

    dv_t r_d, r_q;
    logic [W:0] rem_sh, trial;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        rem_sh  = {r_q.rem, r_q.quo[W-1]};
        trial   = rem_sh - {1'b0, r_q.den};
        if (go) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CW'(W);
            r_d.rem  = '0;
            r_d.quo  = num;
            r_d.den  = den;
        end else if (r_q.busy) begin
            if (!trial[W]) begin
                r_d.rem = trial[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b1};
            end else begin
                r_d.rem = rem_sh[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quo = r_q.quo;
    assign rem = r_q.rem;
    assign vld = r_q.vld;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |-> (r_q.rem < r_q.den)); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !r_q.busy); // R3
endmodule

// File: rtl/thermo_code_conv.sv
module thermo_code_conv
    import thermo_pkg::*;
#(
    parameter int unsigned SMP_IN_W = 16,
    parameter int unsigned SMP_W    = 12,
    parameter int unsigned N_SMP    = 8,
    parameter int unsigned W        = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                smp_vld,
    input  logic [SMP_IN_W-1:0] smp_data,
    input  logic [W-1:0]        trim_hot,
    input  logic [W-1:0]        trim_cold,
    output logic signed [W-1:0] temp_mc,
    output logic                done,
    output logic                err,
    output logic                busy
);
    localparam int unsigned LOG_N = $clog2(N_SMP);
    localparam int unsigned CNT_W = (LOG_N > 0) ? LOG_N : 1;
    localparam int unsigned ACC_W = SMP_W + LOG_N;

    typedef struct packed {
        conv_st_t       st;
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [SMP_W-1:0] hot;
        logic [SMP_W-1:0] cold;
        logic [SMP_W-1:0] corr;
        logic [W-1:0]     scale;
        logic [W-1:0]     prod;
        logic [W-1:0]     temp;
        logic             err;
        logic             done;
    } cv_t;

    cv_t r_d, r_q;

    logic [SMP_W-1:0] hot_val, cold_val, avg;
    logic             div_go, div_vld;
    logic [W-1:0]     div_num, div_den, div_quo, div_rem;
    logic signed [W-1:0] diff_s;
    logic [W-1:0]     steps;
    logic             unused_bits;

    assign unused_bits = ^{smp_data[SMP_IN_W-1:SMP_W], div_quo[W-1:SMP_W]};

    thermo_trim #(.WORD_W(W), .VAL_W(SMP_W), .DEFAULT(HOT_DEF)) i_trim_hot (
        .word(trim_hot), .val(hot_val));
    thermo_trim #(.WORD_W(W), .VAL_W(SMP_W), .DEFAULT(COLD_DEF)) i_trim_cold (
        .word(trim_cold), .val(cold_val));

    thermo_div #(.W(W)) i_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
        .quo(div_quo), .rem(div_rem), .vld(div_vld));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_go   = 1'b0;
        div_num  = '0;
        div_den  = '0;
        steps    = '0;
        avg      = SMP_W'(r_q.acc >> LOG_N);
        diff_s   = signed'(W'(r_q.corr)) - signed'(W'(r_q.cold));
        case (r_q.st)
            S_IDLE: if (start) begin
                r_d.acc  = '0;
                r_d.cnt  = '0;
                r_d.hot  = hot_val;
                r_d.cold = cold_val;
                r_d.st   = S_ACC;
            end
            S_ACC: if (smp_vld) begin
                r_d.acc = r_q.acc + ACC_W'(smp_data[SMP_W-1:0]);
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(N_SMP - 1)) r_d.st = S_CORR_GO;
            end
            S_CORR_GO: begin
                div_go  = 1'b1;
                div_num = W'(avg) * W'(CORR_SCALE);
                div_den = W'(CORR_SCALE) + W'(avg) * W'(CURV_K);
                r_d.st  = S_CORR_WT;
            end
            S_CORR_WT: if (div_vld) begin
                r_d.corr = div_quo[SMP_W-1:0];
                if (r_q.hot <= r_q.cold) begin
                    r_d.temp = '0;
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.st = S_SCL_GO;
                end
            end
            S_SCL_GO: begin
                div_go  = 1'b1;
                div_num = W'(SPAN_MC);
                div_den = W'(r_q.hot) - W'(r_q.cold);
                r_d.st  = S_SCL_WT;
            end
            S_SCL_WT: if (div_vld) begin
                r_d.scale = div_quo;
                r_d.st    = S_MUL;
            end
            S_MUL: begin
                r_d.prod = W'(diff_s * signed'(r_q.scale));
                r_d.st   = S_QNT_GO;
            end
            S_QNT_GO: begin
                div_go  = 1'b1;
                div_num = r_q.prod[W-1] ? (W'(0) - r_q.prod) : r_q.prod;
                div_den = W'(GRAN_MC);
                r_d.st  = S_QNT_WT;
            end
            S_QNT_WT: if (div_vld) begin
                if (r_q.prod[W-1])
                    steps = W'(0) - div_quo * W'(GRAN_MC);
                else
                    steps = (div_quo + W'(div_rem != '0)) * W'(GRAN_MC);
                r_d.temp = steps - W'(OFFSET_MC);
                r_d.err  = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign temp_mc = signed'(r_q.temp);
    assign done    = r_q.done;
    assign err     = r_q.err;
    assign busy    = (r_q.st != S_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (temp_mc == '0)); // R7
    AST_GRID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((temp_mc % 500) == 0)); // R6
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ACC && start && !smp_vld) |=> $stable(r_q.cnt)); // R8
endmodule

// File: tb/test_thermo_code_conv.sv
module test_thermo_code_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_data = '0;
    logic [31:0] trim_hot = '0;
    logic [31:0] trim_cold = '0;
    logic signed [31:0] temp_mc;
    logic        done, err, busy;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    thermo_code_conv i_thermo_code_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld),
        .smp_data(smp_data), .trim_hot(trim_hot), .trim_cold(trim_cold),
        .temp_mc(temp_mc), .done(done), .err(err), .busy(busy));

    localparam int NV = 9;
    localparam logic [31:0] V_HOT  [NV] = '{32'h80000C4C, 32'h0, 32'h80000D00, 32'h0,
        32'h80000FFF, 32'h80000400, 32'h80000500, 32'h00000100, 32'h0};
    localparam logic [31:0] V_COLD [NV] = '{32'h800001F7, 32'h0, 32'h80000180, 32'h0,
        32'h80000000, 32'h8000041F, 32'h80000500, 32'h80000200, 32'h0};
    localparam logic [11:0] V_BASE [NV] = '{12'd1500, 12'd2000, 12'd3000, 12'd100,
        12'd4088, 12'd1200, 12'd900, 12'd2500, 12'd0};
    localparam logic [11:0] V_STEP [NV] = '{12'd3, 12'd1, 12'd7, 12'd0,
        12'd1, 12'd5, 12'd2, 12'd11, 12'd0};
    localparam logic       V_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic void model(input logic [31:0] th, input logic [31:0] tc,
                                  input longint sum, output longint t, output logic e);
        longint hv, cv, avg, corr, scale, u, q;
        hv  = th[31] ? longint'(th[11:0]) : 3148;
        cv  = tc[31] ? longint'(tc[11:0]) : 503;
        avg = sum / 8;
        corr = (avg * 1000000) / (1000000 + avg * 13);
        if (hv <= cv) begin
            e = 1'b1; t = 0;
        end else begin
            e = 1'b0;
            scale = 165000 / (hv - cv);
            u = (corr - cv) * scale - 40000;
            q = u / 500;
            if (u - q * 500 > 0) q = q + 1;
            t = q * 500;
        end
    endfunction

    // mode: 0 plain, 1 start pulse mid-collection, 2 trims changed after start
    task automatic conv(input string tag, input logic [31:0] th, input logic [31:0] tc,
                        input logic [11:0] base, input logic [11:0] step, input int mode,
                        input logic exp_err_tab, input int use_tab);
        longint sum = 0, et;
        logic   ee;
        int     waited = 0;
        logic signed [31:0] held;
        @(negedge clk);
        trim_hot = th; trim_cold = tc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R8 busy after start"}, longint'(busy), 1);
        if (mode == 2) begin
            trim_hot = 32'h80000001; trim_cold = 32'h80000FFF;
        end
        for (int i = 0; i < 8; i++) begin
            logic [11:0] code;
            code = base + 12'(i) * step;
            sum += longint'(code);
            smp_vld = 1'b1;
            smp_data = {4'(i + 9), code};   // R1: upper bits carry junk
            @(negedge clk);
            smp_vld = 1'b0;
            if (i == 3 && mode == 1) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (i[0]) @(negedge clk);
        end
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R10 done seen"}, longint'(done), 1);
        model(th, tc, sum, et, ee);
        if (use_tab != 0) chk({tag, " R7 table err"}, longint'(ee), longint'(exp_err_tab));
        chk({tag, " R5/R6 temp"}, longint'(temp_mc), et);
        chk({tag, " R7 err"}, longint'(err), longint'(ee));
        held = temp_mc;
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, longint'(done), 0);
        chk({tag, " R10 temp held"}, longint'(temp_mc), longint'(held));
        chk({tag, " R8 idle after done"}, longint'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset temp", longint'(temp_mc), 0);
        chk("R11 reset err", longint'(err), 0);
        chk("R11 reset done", longint'(done), 0);
        chk("R11 reset busy", longint'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++)
            conv($sformatf("vec%0d", v), V_HOT[v], V_COLD[v], V_BASE[v], V_STEP[v],
                 0, V_ERR[v], 1);

        // R9: samples while idle are ignored; start clears previous sum
        for (int k = 0; k < 3; k++) begin
            smp_vld = 1'b1; smp_data = 16'hFFFF;
            @(negedge clk);
        end
        smp_vld = 1'b0;
        chk("R9 idle samples no busy", longint'(busy), 0);
        conv("R9 idle ignored", 32'h80000C4C, 32'h800001F7, 12'd1500, 12'd3, 0, 1'b0, 0);

        // R8: start during collection does not restart
        conv("R8 mid start", 32'h0, 32'h0, 12'd200, 12'd400, 1, 1'b0, 0);

        // R4: trim words captured at start
        conv("R4 trim latched", 32'h80000C00, 32'h80000200, 12'd1800, 12'd9, 2, 1'b0, 0);

        // R1: code 4095 with junk upper bits
        conv("R1 max code", 32'h0, 32'h0, 12'd4095, 12'd0, 0, 1'b0, 0);

        // R6: negative result near the grid
        conv("R6 negative", 32'h0, 32'h0, 12'd480, 12'd1, 0, 1'b0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule